// File: doc/BRIEF.md
# SHA-1 Message Padding Generator

This block turns a raw message, given as a byte count and a stream of 32-bit words, into the padded word stream that a SHA-1 compression engine consumes. Each 512-bit block leaves the block as 16 consecutive words. The message words pass through unchanged. The block then adds the single 1 bit, the zero fill, and the 64-bit message length in bits, so that the stream ends on a 512-bit boundary.

A controller pulses `start` together with the byte count. The block then pulls message words over a valid/ready input channel and emits padded words over a valid/ready output channel. Once every message byte has been taken, the input channel stays idle and the remaining words come from internal padding only. A separate combinational output reports how many 512-bit blocks the padded message occupies for the byte count currently on `len_bytes`. This count includes the case where the 64-bit length field spills into an extra block.

The control state machine has three states:

- `ST_IDLE` waits for `start`. It goes to `ST_FEED` when the length is nonzero, and to `ST_FILL` when the length is zero.
- `ST_FEED` forwards message words. It goes to `ST_FILL` when the last word holding message bytes is transferred.
- `ST_FILL` emits the marker, zero and length words. It goes back to `ST_IDLE` when the final word of the last block is transferred.

Top module: `msg_padder`

## Requirements
- R1: After reset, `out_valid`, `in_ready` and `out_last` are low.
- R2: `blk_count` equals ((L + 8) >> 6) + 1 for the byte count L on `len_bytes`, truncated to 16 bits. For example, L = 55 gives 1, L = 56 gives 2, and L = 120 gives 3.
- R3: Every input word that holds 4 message bytes is output unchanged and in order. Bytes are big-endian: the first byte is in bits 31:24.
- R4: When L mod 4 is r ≠ 0, the final message word is output with its upper r bytes kept. Byte lane r, counted from bits 31:24, holds 0x80, and the lower lanes are zero.
- R5: When L mod 4 is 0, the marker is a separate word of value 0x80000000 that directly follows the last message word. For L = 0 it is the first word.
- R6: Every word between the marker word and word 14 of the last block is zero.
- R7: Words 14 and 15 of the last block carry L·8 as a 64-bit value, with the upper 32 bits in word 14 and the lower 32 bits in word 15.
- R8: `in_ready` stays low once all ceil(L/4) message words have been taken. Input words offered after that point do not change the output.
- R9: `out_last` is high only while the final word of the last block is offered. After that word is transferred, `out_valid` drops and a new `start` is accepted.
- R10: While a padding word is offered and `out_ready` is low, `out_word` and `out_valid` hold until the word is taken.
- R11: A `start` pulse during an active message is ignored, and the running message completes unaltered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin padding a message of `len_bytes` bytes |
| len_bytes | input | 32 | Message length in bytes |
| blk_count | output | 16 | Number of 512-bit blocks for `len_bytes` |
| in_valid | input | 1 | Message word available |
| in_ready | output | 1 | Message word accepted this cycle |
| in_word | input | 32 | Message word, big-endian bytes |
| out_valid | output | 1 | Padded word available |
| out_ready | input | 1 | Consumer accepts padded word |
| out_word | output | 32 | Padded word |
| out_last | output | 1 | Final word of the final block |

## Verification
The hardest situations to reach are the spill boundary and stalls at the hand-off between message words and padding words. At the spill boundary, L mod 64 is 56 or more, so the marker fits but the length field does not. Stalls at the hand-off matter because back-pressure there could duplicate or drop the marker. The stimulus therefore walks lengths on both sides of 56 and of 64, with each remainder mod 4. It also runs some messages with gaps in the input and with `out_ready` toggling, so that stalls fall inside message words, on the marker word, and on the length words. Garbage words offered on the input during fill show whether the output stays untouched.

// File: rtl/pad_pkg.sv
package pad_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_FEED = 2'd1,
        ST_FILL = 2'd2
    } pad_state_t;

    localparam logic [31:0] MARK_WORD = 32'h8000_0000;
endpackage

// File: rtl/pad_blk_count.sv
module pad_blk_count #(
    parameter int LEN_W = 32,
    localparam int BLK_W = LEN_W - 5
) (
    input  logic [LEN_W-1:0] len,
    output logic [BLK_W-1:0] blocks
);
    logic [LEN_W:0] biased;

    always_comb begin
        biased = {1'b0, len} + (LEN_W + 1)'(8);
        blocks = BLK_W'(biased >> 6) + BLK_W'(1);
    end
endmodule

// File: rtl/pad_word_mux.sv
module pad_word_mux #(
    parameter int LEN_W = 32
) (
    input  logic [LEN_W-1:0] idx,
    input  logic [LEN_W-1:0] len,
    input  logic [LEN_W-1:0] total,
    input  logic [31:0]      in_word,
    output logic [31:0]      word
);
    import pad_pkg::*;

    logic [LEN_W-1:0] full_words;
    logic [1:0]       rem;
    logic [63:0]      bit_len;
    logic [31:0]      keep_mask;

    always_comb begin
        full_words = len >> 2;
        rem        = len[1:0];
        bit_len    = 64'(len) << 3;
        keep_mask  = ~(32'hFFFF_FFFF >> (8 * rem));
        if (idx < full_words) begin
            word = in_word;
        end else if (idx == full_words) begin
            if (rem == 2'd0) word = MARK_WORD;
            else             word = (in_word & keep_mask) | (32'h80 << (8 * (3 - rem)));
        end else if (idx == total - LEN_W'(2)) begin
            word = bit_len[63:32];
        end else if (idx == total - LEN_W'(1)) begin
            word = bit_len[31:0];
        end else begin
            word = '0;
        end
    end
endmodule

// File: rtl/msg_padder.sv
module msg_padder #(
    parameter int LEN_W = 32,
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [LEN_W-1:0] len_bytes,
    output logic [CNT_W-1:0] blk_count,
    input  logic             in_valid,
    output logic             in_ready,
    input  logic [31:0]      in_word,
    output logic             out_valid,
    input  logic             out_ready,
    output logic [31:0]      out_word,
    output logic             out_last
);
    import pad_pkg::*;

    localparam int BLK_W = LEN_W - 5;

    pad_state_t       state;
    logic [LEN_W-1:0] idx;
    logic [LEN_W-1:0] len_q;
    logic [BLK_W-1:0] port_blocks;
    logic [BLK_W-1:0] run_blocks;
    logic [LEN_W-1:0] total_words;
    logic [LEN_W-1:0] need_words;
    logic             fire;

    pad_blk_count #(.LEN_W(LEN_W)) u_cnt_port (.len(len_bytes), .blocks(port_blocks));
    pad_blk_count #(.LEN_W(LEN_W)) u_cnt_run  (.len(len_q),     .blocks(run_blocks));

    pad_word_mux #(.LEN_W(LEN_W)) u_mux (
        .idx     (idx),
        .len     (len_q),
        .total   (total_words),
        .in_word (in_word),
        .word    (out_word)
    );

    always_comb begin
        blk_count   = CNT_W'(port_blocks);
        total_words = LEN_W'({run_blocks, 4'b0000});
        need_words  = LEN_W'(({1'b0, len_q} + (LEN_W + 1)'(3)) >> 2);
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            idx   <= '0;
            len_q <= '0;
        end else begin
            unique case (state)
                ST_IDLE: if (start) begin
                    len_q <= len_bytes;
                    idx   <= '0;
                    state <= (len_bytes == '0) ? ST_FILL : ST_FEED;
                end
                ST_FEED: if (fire) begin
                    idx <= idx + LEN_W'(1);
                    if (idx == need_words - LEN_W'(1)) state <= ST_FILL;
                end
                ST_FILL: if (fire) begin
                    idx <= idx + LEN_W'(1);
                    if (idx == total_words - LEN_W'(1)) state <= ST_IDLE;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // outputs
    always_comb begin
        out_valid = 1'b0;
        in_ready  = 1'b0;
        out_last  = 1'b0;
        unique case (state)
            ST_IDLE: ;
            ST_FEED: begin
                out_valid = in_valid;
                in_ready  = out_ready;
            end
            ST_FILL: begin
                out_valid = 1'b1;
                out_last  = (idx == total_words - LEN_W'(1));
            end
            default: ;
        endcase
        fire = out_valid && out_ready;
    end

    p_reset_quiet_r1: assert property (@(posedge clk) !rst_n |=> !out_valid && !in_ready);

    p_len_bytes_r7: assert property (@(posedge clk) disable iff (!rst_n)
        out_last |-> out_word[2:0] == 3'b000);

    p_no_input_in_fill_r8: assert property (@(posedge clk) disable iff (!rst_n)
        state == ST_FILL |-> !in_ready);

    p_idx_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> idx < total_words);

    p_idle_after_last_r9: assert property (@(posedge clk) disable iff (!rst_n)
        out_last && out_ready |=> !out_valid);

    p_fill_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        state == ST_FILL && !out_ready |=> out_valid && $stable(out_word));

    p_count_nonzero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        run_blocks != '0);
endmodule

// File: tb/sim_msg_padder.sv
module sim_msg_padder;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [31:0] len_bytes = '0;
    logic [15:0] blk_count;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [31:0] in_word = '0;
    logic        out_valid;
    logic        out_ready = 1'b0;
    logic [31:0] out_word;
    logic        out_last;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    always #2 clk = ~clk;   // 250 MHz

    msg_padder u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .len_bytes(len_bytes),
        .blk_count(blk_count), .in_valid(in_valid), .in_ready(in_ready),
        .in_word(in_word), .out_valid(out_valid), .out_ready(out_ready),
        .out_word(out_word), .out_last(out_last)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] pat(input int k);
        return 32'hA1B2_C3D4 ^ (k * 32'h0101_0107);
    endfunction

    function automatic int blocks_of(input longint l);
        return int'(((l + 8) >> 6) + 1);
    endfunction

    function automatic logic [31:0] exp_word(input int l, input int k);
        int full = l / 4;
        int r = l % 4;
        int tot = blocks_of(l) * 16;
        logic [63:0] bits = 64'(l) << 3;
        if (k < full) return pat(k);
        if (k == full) begin
            if (r == 0) return 32'h8000_0000;
            return (pat(k) & ~(32'hFFFF_FFFF >> (8 * r))) | (32'h80 << (8 * (3 - r)));
        end
        if (k == tot - 2) return bits[63:32];
        if (k == tot - 1) return bits[31:0];
        return 32'h0;
    endfunction

    // one message; gap_in drops in_valid on odd cycles, stall toggles out_ready,
    // restart pulses start mid-stream with another length (R11)
    task automatic run_msg(input int l, input bit gap_in, input bit stall, input bit restart);
        int k = 0;
        int need = (l + 3) / 4;
        int tot = blocks_of(l) * 16;
        int cyc = 0;
        bit held = 0;
        logic [31:0] held_word = '0;
        @(negedge clk);
        len_bytes = l;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        while (k < tot && cycles < 100000) begin
            in_valid  = (k < need) ? !(gap_in && cyc[0]) : 1'b1;
            in_word   = (k < need) ? pat(k) : 32'hDEAD_BEEF;  // garbage in fill (R8)
            out_ready = !(stall && (cyc % 3 == 1));
            if (restart && cyc == 5) begin
                start = 1'b1;
                len_bytes = l + 13;
            end else begin
                start = 1'b0;
            end
            #1;
            if (held) begin
                check("R10 hold", out_word, held_word);
                check("R10 valid", 32'(out_valid), 32'd1);
            end
            held = 0;
            if (k >= need) check("R8 in_ready low", 32'(in_ready), 32'd0);
            if (out_valid) begin
                check("R9 last flag", 32'(out_last), 32'(k == tot - 1));
                if (out_ready) begin
                    if (k < l / 4)        check("R3 data word", out_word, exp_word(l, k));
                    else if (k == l / 4)  check((l % 4 == 0) ? "R5 marker word" : "R4 partial word", out_word, exp_word(l, k));
                    else if (k >= tot - 2) check("R7 length word", out_word, exp_word(l, k));
                    else                  check("R6 zero fill", out_word, exp_word(l, k));
                    k++;
                end else if (k >= need) begin
                    held = 1;
                    held_word = out_word;
                end
            end
            cyc++;
            @(negedge clk);
        end
        start = 1'b0;
        in_valid = 1'b0;
        out_ready = 1'b1;
        #1;
        check("R9 idle after last", 32'(out_valid), 32'd0);
    endtask

    task automatic test_count(input longint l);
        @(negedge clk);
        len_bytes = 32'(l);
        #1;
        check("R2 block count", 32'(blk_count), 32'(16'(((l + 8) >> 6) + 1)));
    endtask

    initial begin
        #1;
        check("R1 out_valid", 32'(out_valid), 32'd0);
        check("R1 in_ready", 32'(in_ready), 32'd0);
        check("R1 out_last", 32'(out_last), 32'd0);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        test_count(0); test_count(55); test_count(56); test_count(63);
        test_count(64); test_count(119); test_count(120); test_count(32'hFFFF_FFFF);
        run_msg(0, 0, 0, 0);
        run_msg(3, 0, 0, 0);
        run_msg(4, 0, 1, 0);
        run_msg(55, 1, 0, 0);
        run_msg(56, 0, 1, 0);
        run_msg(57, 1, 1, 0);
        run_msg(64, 0, 0, 1);
        run_msg(112, 1, 1, 0);
        run_msg(118, 0, 1, 1);
        run_msg(120, 0, 0, 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles == 150000) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual %0d expected below %0d", cycles, 150000);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule